// File: doc/BRIEF.md
# Quantised Coefficient Rebuilder for 8x8 Image Blocks

This block sits behind a Huffman symbol decoder in an image decompression pipeline and turns a stream of decoded symbols back into the 64 quantised coefficients of one 8x8 data unit. Each incoming symbol is one 32-bit word holding a zero-run length, a size category and the raw amplitude bits. The first symbol of every unit is the DC term. It is decoded as a difference against one of several predictors, and the external `pred_sel` input chooses which predictor, one per colour component. All later symbols are AC terms. The block expands each AC symbol into its run of zeros followed by one non-zero value.

Coefficients leave one per clock in the order they arrive, which is zigzag scan order, flagged by `coef_valid`. `coef_last` marks the 64th coefficient of each unit. While a zero run is being expanded the block lowers `sym_ready`, so the symbol source never needs to buffer. A `restart` pulse zeroes every predictor, as needed at a restart marker in the compressed stream.

Top module: `coef_rebuild`

## Requirements
- R1: A symbol word carries its run length in bits [31:28] and its size category in bits [27:24]. Its raw amplitude sits in the low `size` bits of [15:0]. Bits [23:16] and any raw bits above `size` are ignored.
- R2: The amplitude is recovered as follows. Size 0 gives zero. A raw value whose top bit (bit size-1) is 1 is taken as is. Otherwise the value is the raw bits minus (2^size - 1).
- R3: The first symbol of a unit is DC. Its output is the selected predictor plus the decoded difference, wrapped to 12-bit two's complement, and that sum is written back into the same predictor.
- R4: Predictors are independent. A DC symbol changes only the predictor chosen by `pred_sel` at the time it is accepted.
- R5: A one-cycle `restart` pulse sets every predictor to zero.
- R6: An AC symbol with run r and nonzero size emits r zero coefficients and then its amplitude.
- R7: An AC symbol with run 15 and size 0 emits 16 zero coefficients.
- R8: An AC symbol with run 0 and size 0 fills every remaining position up to index 63 with zeros.
- R9: `coef_last` is high on exactly the 64th valid coefficient of each unit and on no other. The next accepted symbol is then DC.
- R10: `sym_ready` is low only while a zero run has more than one cycle of output still to go. A symbol offered during a run of r zeros before a value waits r cycles.
- R11: The first coefficient of a symbol appears on the cycle after the symbol is accepted. When symbols are offered continuously, coefficients come out on consecutive cycles with no gaps.
- R12: After reset `coef_valid` and `coef_last` are low, `sym_ready` is high and every predictor holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Zeroes all predictors |
| pred_sel | input | PSEL_W (2) | Predictor used by the DC symbol being accepted |
| sym_valid | input | 1 | Symbol word offered |
| sym_word | input | 32 | Run, size and raw amplitude of one symbol |
| sym_ready | output | 1 | Block takes the offered symbol at this edge |
| coef_valid | output | 1 | A coefficient is present on `coef_data` |
| coef_data | output | COEF_W (12) | Signed coefficient, zigzag order |
| coef_last | output | 1 | Coefficient at index 63 of the unit |

## Verification
The checker assumes that the symbol source sends well-formed units. Runs plus values never step past index 63. A size-0 AC symbol only ever uses run 0 or run 15. Sizes stay below the coefficient width, and `pred_sel` names an existing predictor. Under these assumptions the unit counter in the checker always agrees with `coef_last`, and every hold-off cycle carries a zero. The directed bench builds each unit from intended values, encodes the amplitudes by the inverse of R2, and keeps every run within the unit. It pulses `restart` only between units, never in the cycle a DC symbol is taken.

// File: rtl/coef_rebuild_pkg.sv
package coef_rebuild_pkg;

   localparam int SYM_W = 32;

   // field positions are decoded by the symbol producer; keep them fixed
   typedef struct packed {
      logic [3:0]  run;
      logic [3:0]  size;
      logic [7:0]  spare;
      logic [15:0] raw;
   } sym_t;

endpackage

// File: rtl/amp_decode.sv
module amp_decode #(
   parameter int COEF_W = 12
) (
   input  logic [3:0]        size,
   input  logic [15:0]       raw,
   output logic [COEF_W-1:0] value
);

   logic [16:0] mask;
   logic [16:0] kept;
   logic [16:0] shifted;
   logic        top;

   always_comb begin
      mask    = (17'd1 << size) - 17'd1;
      kept    = {1'b0, raw} & mask;
      shifted = kept - mask;
      top     = (size != 4'd0) ? raw[size - 4'd1] : 1'b0;
      if (size == 4'd0)
         value = '0;
      else if (top)
         value = kept[COEF_W-1:0];
      else
         value = shifted[COEF_W-1:0];
   end

endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
   parameter int COEF_W = 12,
   parameter int N_PRED = 4,
   parameter int PSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [PSEL_W-1:0] sel,
   input  logic [COEF_W-1:0] wr_data,
   output logic [COEF_W-1:0] rd_data
);

   generate
      if (N_PRED == 1) begin : g_single
         logic [COEF_W-1:0] only_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      only_q <= '0;
            else if (clear)  only_q <= '0;
            else if (wr_en)  only_q <= wr_data;
         end
         assign rd_data = only_q;
      end else begin : g_multi
         logic [COEF_W-1:0] bank_q [N_PRED];
         for (genvar g = 0; g < N_PRED; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  bank_q[g] <= '0;
               else if (clear)
                  bank_q[g] <= '0;
               else if (wr_en && (int'(sel) == g))
                  bank_q[g] <= wr_data;
            end
         end
         assign rd_data = (int'(sel) < N_PRED) ? bank_q[sel] : '0;
      end
   endgenerate

endmodule

// File: rtl/zero_run_seq.sv
module zero_run_seq #(
   parameter int COEF_W = 12,
   parameter int IW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IW:0]       load_zeros,
   input  logic              load_has_val,
   input  logic [COEF_W-1:0] load_val,
   output logic              valid,
   output logic [COEF_W-1:0] data,
   output logic              last,
   output logic              ready,
   output logic [IW-1:0]     next_pos
);

   localparam logic [IW-1:0] LAST_POS = '1;

   logic [IW:0]       zeros_q;
   logic              has_val_q;
   logic [COEF_W-1:0] val_q;
   logic [IW-1:0]     pos_q;

   assign valid    = (zeros_q != '0) || has_val_q;
   assign data     = (zeros_q != '0) ? '0 : val_q;
   assign last     = valid && (pos_q == LAST_POS);
   assign ready    = (zeros_q == '0) || ((zeros_q == {{IW{1'b0}}, 1'b1}) && !has_val_q);
   assign next_pos = pos_q + {{(IW-1){1'b0}}, valid};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zeros_q   <= '0;
         has_val_q <= 1'b0;
         val_q     <= '0;
         pos_q     <= '0;
      end else begin
         if (valid) begin
            pos_q <= pos_q + 1'b1;
            if (zeros_q != '0) zeros_q <= zeros_q - 1'b1;
            else               has_val_q <= 1'b0;
         end
         if (load) begin
            zeros_q   <= load_zeros;
            has_val_q <= load_has_val;
            val_q     <= load_val;
         end
      end
   end

endmodule

// File: rtl/coef_rebuild.sv
module coef_rebuild #(
   parameter int COEF_W = 12,
   parameter int N_PRED = 4,
   parameter int BLK    = 8,
   parameter int PSEL_W = (N_PRED > 1) ? $clog2(N_PRED) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic [PSEL_W-1:0]        pred_sel,
   input  logic                     sym_valid,
   input  logic [31:0]              sym_word,
   output logic                     sym_ready,
   output logic                     coef_valid,
   output logic signed [COEF_W-1:0] coef_data,
   output logic                     coef_last
);
   import coef_rebuild_pkg::*;

   localparam int UNIT_LEN = BLK * BLK;
   localparam int IW       = $clog2(UNIT_LEN);

   if (COEF_W < 2 || COEF_W > 16) begin : g_bad_width
      $error("coef_rebuild: COEF_W must lie in 2..16");
   end
   if (N_PRED < 1) begin : g_bad_pred
      $error("coef_rebuild: N_PRED must be at least 1");
   end
   if ((UNIT_LEN & (UNIT_LEN - 1)) != 0 || UNIT_LEN < 4) begin : g_bad_blk
      $error("coef_rebuild: BLK*BLK must be a power of two");
   end

   sym_t              sym;
   logic              accept;
   logic              is_dc;
   logic [COEF_W-1:0] amp;
   logic [COEF_W-1:0] pred_rd;
   logic [COEF_W-1:0] dc_sum;
   logic [IW:0]       zeros_ld;
   logic              val_ld_en;
   logic [COEF_W-1:0] val_ld;
   logic [IW-1:0]     pos_next;
   logic [COEF_W-1:0] out_data;

   assign sym    = sym_t'(sym_word);
   assign accept = sym_valid && sym_ready;
   assign is_dc  = (pos_next == '0);
   assign dc_sum = pred_rd + amp;

   amp_decode #(.COEF_W(COEF_W)) u_amp (
      .size  (sym.size),
      .raw   (sym.raw),
      .value (amp)
   );

   pred_bank #(.COEF_W(COEF_W), .N_PRED(N_PRED), .PSEL_W(PSEL_W)) u_pred (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart),
      .wr_en   (accept && is_dc),
      .sel     (pred_sel),
      .wr_data (dc_sum),
      .rd_data (pred_rd)
   );

   always_comb begin
      if (is_dc) begin
         zeros_ld  = '0;
         val_ld_en = 1'b1;
         val_ld    = dc_sum;
      end else if (sym.size != 4'd0) begin
         zeros_ld  = (IW+1)'(sym.run);
         val_ld_en = 1'b1;
         val_ld    = amp;
      end else if (sym.run == 4'd0) begin
         zeros_ld  = (IW+1)'(UNIT_LEN) - {1'b0, pos_next};
         val_ld_en = 1'b0;
         val_ld    = '0;
      end else begin
         zeros_ld  = (IW+1)'(sym.run) + 1'b1;
         val_ld_en = 1'b0;
         val_ld    = '0;
      end
   end

   zero_run_seq #(.COEF_W(COEF_W), .IW(IW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (accept),
      .load_zeros   (zeros_ld),
      .load_has_val (val_ld_en),
      .load_val     (val_ld),
      .valid        (coef_valid),
      .data         (out_data),
      .last         (coef_last),
      .ready        (sym_ready),
      .next_pos     (pos_next)
   );

   assign coef_data = $signed(out_data);

endmodule

// File: rtl/coef_rebuild_chk.sv
module coef_rebuild_chk #(
   parameter int COEF_W = 12,
   parameter int BLK    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sym_valid,
   input logic              sym_ready,
   input logic              coef_valid,
   input logic [COEF_W-1:0] coef_data,
   input logic              coef_last
);
   localparam int UNIT_LEN = BLK * BLK;
   localparam int IW       = $clog2(UNIT_LEN);

   logic [IW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen_q <= '0;
      else if (coef_valid) seen_q <= seen_q + 1'b1;
   end

   // R9: end-of-unit flag agrees with an independent count of coefficients
   p_last_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid |-> (coef_last == (int'(seen_q) == UNIT_LEN - 1)));

   // R9: the flag never appears without a coefficient
   p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      coef_last |-> coef_valid);

   // R11: an accepted symbol produces output on the next cycle
   p_accept_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_ready) |=> coef_valid);

   // R10: input is held off only while zeros are streaming out
   p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_ready |-> (coef_valid && coef_data == '0));

   // R11: a hold-off never ends in an output gap
   p_hold_cont_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_ready |=> coef_valid);

endmodule

bind coef_rebuild coef_rebuild_chk #(.COEF_W(COEF_W), .BLK(BLK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sym_valid  (sym_valid),
   .sym_ready  (sym_ready),
   .coef_valid (coef_valid),
   .coef_data  (coef_data),
   .coef_last  (coef_last)
);

// File: tb/tb_coef_rebuild.sv
`timescale 1ns/1ps
module tb_coef_rebuild;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic [1:0]  pred_sel = '0;
   logic        sym_valid = 1'b0;
   logic [31:0] sym_word = '0;
   logic        sym_ready;
   logic        coef_valid;
   logic signed [11:0] coef_data;
   logic        coef_last;

   always #2.5 clk = ~clk;

   coef_rebuild dut (
      .clk(clk), .rst_n(rst_n), .restart(restart), .pred_sel(pred_sel),
      .sym_valid(sym_valid), .sym_word(sym_word), .sym_ready(sym_ready),
      .coef_valid(coef_valid), .coef_data(coef_data), .coef_last(coef_last)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ncap = 0;
   int last_wait = 0;
   int cap_d [256];
   bit cap_l [256];
   int cap_t [256];
   int exp_c [256];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && coef_valid && ncap < 256) begin
         cap_d[ncap] = int'(coef_data);
         cap_l[ncap] = coef_last;
         cap_t[ncap] = cyc;
         ncap = ncap + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [31:0] mk(input int run, input int size, input int val);
      int raw;
      logic [31:0] w;
      raw = (val >= 0) ? val : val + (1 << size) - 1;
      w = '0;
      w[31:28] = run[3:0];
      w[27:24] = size[3:0];
      w[23:16] = 8'hA5;           // R1: spare bits carry junk, must be ignored
      w[15:0]  = raw[15:0];
      return w;
   endfunction

   task automatic put(input logic [31:0] w, input int sel);
      sym_word  = w;
      pred_sel  = sel[1:0];
      sym_valid = 1'b1;
      last_wait = 0;
      while (!sym_ready) begin
         last_wait++;
         @(negedge clk);
      end
      @(negedge clk);
      sym_valid = 1'b0;
   endtask

   task automatic clear_cap();
      ncap = 0;
      for (int i = 0; i < 256; i++) exp_c[i] = 0;
   endtask

   task automatic check_units(input string req, input int n);
      int guard;
      int bad_i;
      int bad_l;
      guard = 0;
      while (ncap < n && guard < 600) begin
         @(negedge clk);
         guard++;
      end
      chk(ncap == n, req, "coefficient count", ncap, n);
      bad_i = -1;
      bad_l = -1;
      for (int i = 0; i < n; i++) begin
         if (bad_i < 0 && cap_d[i] != exp_c[i]) bad_i = i;
         if (bad_l < 0 && cap_l[i] != ((i % 64) == 63)) bad_l = i;
      end
      if (bad_i < 0) chk(1'b1, req, "data", 0, 0);
      else chk(1'b0, req, $sformatf("data at %0d", bad_i), cap_d[bad_i], exp_c[bad_i]);
      if (bad_l < 0) chk(1'b1, "R9", "last flag", 0, 0);
      else chk(1'b0, "R9", $sformatf("last flag at %0d", bad_l), int'(cap_l[bad_l]), int'((bad_l % 64) == 63));
   endtask

   task automatic t_reset();
      chk(coef_valid == 1'b0, "R12", "coef_valid after reset", int'(coef_valid), 0);
      chk(coef_last == 1'b0, "R12", "coef_last after reset", int'(coef_last), 0);
      chk(sym_ready == 1'b1, "R12", "sym_ready after reset", int'(sym_ready), 1);
   endtask

   task automatic t_dc_basic();      // R3 R2 R8: pred0 0 -> 5
      clear_cap();
      put(mk(0, 3, 5), 0); exp_c[0] = 5;
      put(mk(0, 0, 0), 0);
      check_units("R8", 64);
   endtask

   task automatic t_pred_sel();      // R4: pred0 5 -> 2, pred1 0 -> 7, pred0 stays 2
      clear_cap();
      put(mk(0, 2, -3), 0); put(mk(0, 0, 0), 0); exp_c[0] = 2;
      put(mk(0, 3, 7), 1);  put(mk(0, 0, 0), 1); exp_c[64] = 7;
      put(mk(0, 0, 0), 0);  put(mk(0, 0, 0), 0); exp_c[128] = 2;
      check_units("R4", 192);
   endtask

   task automatic t_ac_runs();       // R6 R2 R1
      clear_cap();
      put(mk(0, 0, 0), 2);            exp_c[0] = 0;
      put(mk(2, 1, -1), 2);           exp_c[3] = -1;
      put(mk(0, 4, 9), 2);            exp_c[4] = 9;
      put(mk(0, 10, -600), 2);        exp_c[5] = -600;
      put(mk(0, 0, 0), 2);
      check_units("R6", 64);
   endtask

   task automatic t_zrl();           // R7: pred3 0 -> 3
      clear_cap();
      put(mk(0, 2, 3), 3);            exp_c[0] = 3;
      put(mk(15, 0, 0), 3);
      put(mk(15, 0, 0), 3);
      put(mk(3, 2, 2), 3);            exp_c[36] = 2;
      put(mk(0, 0, 0), 3);
      check_units("R7", 64);
   endtask

   task automatic t_hold();          // R10: pred3 stays 3
      clear_cap();
      put(mk(0, 0, 0), 3);            exp_c[0] = 3;
      put(mk(5, 1, 1), 3);            exp_c[6] = 1;
      put(mk(0, 0, 0), 3);
      chk(last_wait == 5, "R10", "hold-off cycles for a run of 5", last_wait, 5);
      check_units("R10", 64);
   endtask

   task automatic t_full();          // R9 R11: no end-of-block symbol, pred0 = 2
      bit gap;
      clear_cap();
      put(mk(0, 0, 0), 0);            exp_c[0] = 2;
      for (int i = 1; i < 64; i++) begin
         put(mk(0, 1, (i % 2 == 1) ? 1 : -1), 0);
         exp_c[i] = (i % 2 == 1) ? 1 : -1;
      end
      check_units("R9", 64);
      gap = 1'b0;
      for (int i = 1; i < 64; i++) if (cap_t[i] != cap_t[i-1] + 1) gap = 1'b1;
      chk(!gap, "R11", "gap-free output stream", int'(gap), 0);
   endtask

   task automatic t_restart();       // R5
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      clear_cap();
      put(mk(0, 0, 0), 1); put(mk(0, 0, 0), 1);
      put(mk(0, 0, 0), 0); put(mk(0, 0, 0), 0);
      put(mk(0, 0, 0), 3); put(mk(0, 0, 0), 3);
      check_units("R5", 192);
   endtask

   task automatic t_wrap();          // R3: 2047 + 2047 wraps to -2
      clear_cap();
      put(mk(0, 11, 2047), 0); put(mk(0, 0, 0), 0); exp_c[0] = 2047;
      put(mk(0, 11, 2047), 0); put(mk(0, 0, 0), 0); exp_c[64] = -2;
      check_units("R3", 128);
   endtask

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dc_basic();
      t_pred_sel();
      t_ac_runs();
      t_zrl();
      t_hold();
      t_full();
      t_restart();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule